// File: doc/BRIEF.md
# Converter Offset and Gain Calibration Sequencer

This block runs a two-step hardware calibration of an analog-to-digital converter and keeps the two correction coefficients that result from it. Software writes a control byte with a start bit and a mode bit. The block then asks the converter for a ground measurement and uses it to form the offset coefficient. After that it asks for a reference measurement and uses it, corrected by the ground reading, to form the gain coefficient. Offset is always measured before gain.

In device mode the two measurements use fixed internal channel codes: 4'b1011 for ground and 4'b1100 for reference. In system mode they use two channel numbers that software has placed in a channel register beforehand. Each 14-bit coefficient can be read and written through two byte registers, a low byte and a 6-bit high part. This lets software save and restore calibrations. While a calibration is running, all register writes are ignored.

Top module: `cal_seq`

## Requirements
- R1: After reset, `conv_req` is 0, `chan_sel` is 0, the control register (address 0) reads 0x00, and both coefficients hold 0x2000, so address 2 and address 4 read 0x00 and address 3 and address 5 read 0x20.
- R2: A write to address 0 with bit 0 set, made while idle, starts a calibration. With bit 1 clear (device mode), the first conversion uses channel 4'b1011 and the second uses 4'b1100. The offset step always comes before the gain step.
- R3: With bit 1 of the control write set (system mode), the first conversion uses the ground channel held in address 1 bits [3:0]. The second uses the reference channel held in address 1 bits [7:4].
- R4: The offset coefficient becomes min(8192 + 4*G, 16383). G is the 12-bit ground result. It is loaded on the clock edge where that result is accepted.
- R5: The gain coefficient becomes min(8192 + 4*(4095 - V + G), 16383). V is the 12-bit reference result and G is the earlier ground result. It is loaded on the edge where the reference result is accepted.
- R6: On the clock edge that accepts the reference result, the sequence ends. From the next cycle, control bit 0 (busy/start) reads 0 and bit 2 (done) reads 1. The done bit is cleared when the next calibration starts.
- R7: When idle, software can write the coefficients. Address 2 and address 4 are the low 8 bits of offset and gain. Address 3 and address 5 take their top 6 bits from data bits [5:0]. A read of address 3 or address 5 returns those bits with bits [7:6] as 0.
- R8: During a calibration, writes to any register are ignored. This covers the coefficient bytes, the channel register and the mode bit.
- R9: `conv_req` goes high in the cycle after a step begins. It stays high until the cycle in which `conv_valid` is accepted. It is low whenever no calibration is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 channels, 2/3 offset low/high, 4/5 gain low/high) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| conv_req | output | 1 | Conversion request, held until a result is accepted |
| chan_sel | output | 4 | Channel to convert while `conv_req` is high |
| conv_valid | input | 1 | Converter result is valid this cycle |
| conv_data | input | 12 | Converter result |

## Verification
- **Request and channel (R9, R2, R3):** After a starting write, the request and the channel appear in the following cycle. The converter model in the bench checks the channel against a queue of expected channels that the driver task fills. It checks this as soon as it sees the request.
- **Coefficients (R4, R5):** Each coefficient is due on the edge that accepts its result. The bench reads both coefficients only after the sequence has finished.
- **Completion (R6):** The done flag must be visible exactly one cycle after the edge that accepts the reference result. The bench compares the cycle number on which polling first sees the done flag with the cycle number the converter model recorded when it presented that result.
- **Ignored writes (R8):** These are made while the converter model holds back its answer. They are checked through register reads and through the channel the sequence asks for next.

// File: rtl/cal_pkg.sv
// Package: shared state encoding and register addresses for the calibration
// sequencer. Assumes a 3-bit register address space.
package cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFS  = 2'd1,
        ST_GAIN = 2'd2
    } cal_state_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_CHAN   = 3'd1;
    localparam logic [2:0] A_OFS_LO = 3'd2;
    localparam logic [2:0] A_OFS_HI = 3'd3;
    localparam logic [2:0] A_GN_LO  = 3'd4;
    localparam logic [2:0] A_GN_HI  = 3'd5;

endpackage

// File: rtl/cal_fsm.sv
// cal_fsm: step sequencer. Runs offset then gain, holds the conversion request
// and drives the channel select. Assumes the mode input is stable while busy.
module cal_fsm #(
    parameter int              CH_W       = 4,
    parameter logic [CH_W-1:0] DEV_GND_CH = 4'b1011,
    parameter logic [CH_W-1:0] DEV_REF_CH = 4'b1100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kick,
    input  logic                sys_mode,
    input  logic [CH_W-1:0]     gnd_ch,
    input  logic [CH_W-1:0]     ref_ch,
    input  logic                conv_valid,
    output cal_pkg::cal_state_e st,
    output logic                busy,
    output logic                conv_req,
    output logic [CH_W-1:0]     chan_sel,
    output logic                ofs_load,
    output logic                gain_load
);
    import cal_pkg::*;

    // Advance through idle -> offset -> gain -> idle on each accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (kick)       st <= ST_OFS;
                ST_OFS:  if (conv_valid) st <= ST_GAIN;
                ST_GAIN: if (conv_valid) st <= ST_IDLE;
                default:                 st <= ST_IDLE;
            endcase
        end
    end

    // Pick the channel for the current step from the mode.
    always_comb begin
        case (st)
            ST_OFS:  chan_sel = sys_mode ? gnd_ch : DEV_GND_CH;
            ST_GAIN: chan_sel = sys_mode ? ref_ch : DEV_REF_CH;
            default: chan_sel = '0;
        endcase
    end

    assign busy      = (st != ST_IDLE);
    assign conv_req  = busy;
    assign ofs_load  = (st == ST_OFS)  && conv_valid;
    assign gain_load = (st == ST_GAIN) && conv_valid;

endmodule

// File: rtl/cal_math.sv
// cal_math: coefficient arithmetic. Keeps the ground result and forms
// saturated offset and gain coefficients from the converter result.
// Assumes SUM_W is wide enough for the unsaturated sums at the given scales.
module cal_math #(
    parameter int RES_W      = 12,
    parameter int COEF_W     = 14,
    parameter int OFS_NOM    = 8192,
    parameter int GAIN_NOM   = 8192,
    parameter int OFS_SCALE  = 4,
    parameter int GAIN_SCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              ofs_load,
    output logic [COEF_W-1:0] ofs_new,
    output logic [COEF_W-1:0] gain_new
);
    localparam int SUM_W = COEF_W + 4;
    localparam int FULL  = (1 << RES_W) - 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << COEF_W) - 1);

    logic [RES_W-1:0] gnd_q;
    logic [SUM_W-1:0] ofs_sum, span, gain_sum;

    function automatic logic [COEF_W-1:0] sat(input logic [SUM_W-1:0] v);
        return (v > MAXV) ? MAXV[COEF_W-1:0] : v[COEF_W-1:0];
    endfunction

    // Hold the ground result so the gain step can correct for it.
    always_ff @(posedge clk) begin
        if (!rst_n)        gnd_q <= '0;
        else if (ofs_load) gnd_q <= conv_data;
    end

    // Form both candidate coefficients from the present result.
    always_comb begin
        ofs_sum  = SUM_W'(OFS_NOM) + SUM_W'(conv_data) * SUM_W'(OFS_SCALE);
        span     = SUM_W'(FULL) - SUM_W'(conv_data) + SUM_W'(gnd_q);
        gain_sum = SUM_W'(GAIN_NOM) + span * SUM_W'(GAIN_SCALE);
        ofs_new  = sat(ofs_sum);
        gain_new = sat(gain_sum);
    end

endmodule

// File: rtl/cal_regs.sv
// cal_regs: software register file. Holds the mode, done flag, system channels
// and both coefficients. Blocks every write while busy and decodes the start.
module cal_regs #(
    parameter int CH_W     = 4,
    parameter int COEF_W   = 14,
    parameter int OFS_NOM  = 8192,
    parameter int GAIN_NOM = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic [1:0]        load,
    input  logic [COEF_W-1:0] new_v [2],
    output logic              kick,
    output logic              sys_mode,
    output logic              done_flag,
    output logic [CH_W-1:0]   gnd_ch,
    output logic [CH_W-1:0]   ref_ch,
    output logic [COEF_W-1:0] ofs_coef,
    output logic [COEF_W-1:0] gain_coef
);
    import cal_pkg::*;

    localparam int HI_W = COEF_W - 8;

    logic              wr_ok;
    logic [COEF_W-1:0] coef_q [2];

    assign wr_ok = reg_wr && !busy;
    assign kick  = wr_ok && (reg_addr == A_CTRL) && reg_wdata[0];

    // Control and channel fields: writable only while idle; done tracks completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_mode  <= 1'b0;
            done_flag <= 1'b0;
            gnd_ch    <= '0;
            ref_ch    <= '0;
        end else begin
            if (load[1])                         done_flag <= 1'b1;
            else if (kick)                       done_flag <= 1'b0;
            if (wr_ok && reg_addr == A_CTRL)     sys_mode <= reg_wdata[1];
            if (wr_ok && reg_addr == A_CHAN)     {ref_ch, gnd_ch} <= reg_wdata[2*CH_W-1:0];
        end
    end

    // One coefficient register per step: engine load wins, else idle byte writes.
    for (genvar i = 0; i < 2; i++) begin : g_coef
        localparam logic [2:0]        LO_A  = 3'(2 + 2*i);
        localparam logic [2:0]        HI_A  = 3'(3 + 2*i);
        localparam logic [COEF_W-1:0] RST_V = (i == 0) ? COEF_W'(OFS_NOM) : COEF_W'(GAIN_NOM);
        always_ff @(posedge clk) begin
            if (!rst_n)                         coef_q[i] <= RST_V;
            else if (load[i])                   coef_q[i] <= new_v[i];
            else if (wr_ok && reg_addr == LO_A) coef_q[i][7:0] <= reg_wdata;
            else if (wr_ok && reg_addr == HI_A) coef_q[i][COEF_W-1:8] <= reg_wdata[HI_W-1:0];
        end
    end

    assign ofs_coef  = coef_q[0];
    assign gain_coef = coef_q[1];

    // Read multiplexer; unused addresses read zero.
    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = {5'b0, done_flag, sys_mode, busy};
            A_CHAN:   reg_rdata = 8'({ref_ch, gnd_ch});
            A_OFS_LO: reg_rdata = coef_q[0][7:0];
            A_OFS_HI: reg_rdata = {{(8-HI_W){1'b0}}, coef_q[0][COEF_W-1:8]};
            A_GN_LO:  reg_rdata = coef_q[1][7:0];
            A_GN_HI:  reg_rdata = {{(8-HI_W){1'b0}}, coef_q[1][COEF_W-1:8]};
            default:  reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/cal_seq.sv
// cal_seq: top of the offset/gain calibration sequencer. Connects the register
// file, the step sequencer and the coefficient arithmetic.
// Assumes the converter answers each held request with one conv_valid pulse.
module cal_seq #(
    parameter int              CH_W       = 4,
    parameter int              RES_W      = 12,
    parameter int              COEF_W     = 14,
    parameter logic [CH_W-1:0] DEV_GND_CH = 4'b1011,
    parameter logic [CH_W-1:0] DEV_REF_CH = 4'b1100,
    parameter int              OFS_NOM    = 8192,
    parameter int              GAIN_NOM   = 8192,
    parameter int              OFS_SCALE  = 4,
    parameter int              GAIN_SCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             conv_req,
    output logic [CH_W-1:0]  chan_sel,
    input  logic             conv_valid,
    input  logic [RES_W-1:0] conv_data
);
    cal_pkg::cal_state_e st;
    logic              busy, kick, sys_mode, done_flag, ofs_load, gain_load;
    logic [CH_W-1:0]   gnd_ch, ref_ch;
    logic [COEF_W-1:0] ofs_new, gain_new, ofs_coef, gain_coef;
    logic [COEF_W-1:0] new_v [2];

    assign new_v[0] = ofs_new;
    assign new_v[1] = gain_new;

    cal_regs #(.CH_W(CH_W), .COEF_W(COEF_W), .OFS_NOM(OFS_NOM), .GAIN_NOM(GAIN_NOM)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .load({gain_load, ofs_load}), .new_v(new_v), .kick(kick),
        .sys_mode(sys_mode), .done_flag(done_flag), .gnd_ch(gnd_ch),
        .ref_ch(ref_ch), .ofs_coef(ofs_coef), .gain_coef(gain_coef)
    );

    cal_fsm #(.CH_W(CH_W), .DEV_GND_CH(DEV_GND_CH), .DEV_REF_CH(DEV_REF_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .kick(kick), .sys_mode(sys_mode),
        .gnd_ch(gnd_ch), .ref_ch(ref_ch), .conv_valid(conv_valid), .st(st),
        .busy(busy), .conv_req(conv_req), .chan_sel(chan_sel),
        .ofs_load(ofs_load), .gain_load(gain_load)
    );

    cal_math #(.RES_W(RES_W), .COEF_W(COEF_W), .OFS_NOM(OFS_NOM), .GAIN_NOM(GAIN_NOM),
               .OFS_SCALE(OFS_SCALE), .GAIN_SCALE(GAIN_SCALE)) u_math (
        .clk(clk), .rst_n(rst_n), .conv_data(conv_data), .ofs_load(ofs_load),
        .ofs_new(ofs_new), .gain_new(gain_new)
    );

endmodule

// File: rtl/cal_seq_chk.sv
// cal_seq_chk: protocol and ordering properties of the calibration sequencer,
// attached to cal_seq by bind. Assumes the default channel codes.
module cal_seq_chk #(
    parameter int COEF_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        st,
    input logic              busy,
    input logic              sys_mode,
    input logic              conv_req,
    input logic              conv_valid,
    input logic [3:0]        chan_sel,
    input logic              done_flag,
    input logic [COEF_W-1:0] ofs_coef,
    input logic [COEF_W-1:0] gain_coef
);
    import cal_pkg::*;

    // R2
    dev_gnd_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFS && !sys_mode) |-> chan_sel == 4'b1011);

    // R2
    dev_ref_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAIN && !sys_mode) |-> chan_sel == 4'b1100);

    // R2
    ofs_before_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFS && conv_valid) |=> st == ST_GAIN);

    // R9
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_valid) |=> conv_req);

    // R9
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_req);

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_valid) |=> ($stable(ofs_coef) && $stable(gain_coef)));

    // R6
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAIN && conv_valid) |=> (done_flag && !busy));

endmodule

bind cal_seq cal_seq_chk #(.COEF_W(COEF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .busy(busy), .sys_mode(sys_mode),
    .conv_req(conv_req), .conv_valid(conv_valid), .chan_sel(chan_sel),
    .done_flag(done_flag), .ofs_coef(ofs_coef), .gain_coef(gain_coef)
);

// File: tb/cal_seq_tb.sv
// cal_seq_tb: scoreboard bench. The driver task queues expected channels and
// converter answers; the converter monitor pops and compares them on request.
module cal_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        conv_req;
    logic [3:0]  chan_sel;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = 12'd0;

    int tests = 0, fails = 0, cyc = 0, vcyc = 0, lat = 3;
    int exp_ch[$];
    int rsp_q[$];

    cal_seq u_dut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic rd_coef(input logic [2:0] lo, output int v);
        int l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = (h << 8) | l;
    endtask

    function automatic int ofs_exp(input int g);
        int s = 8192 + 4 * g;
        return (s > 16383) ? 16383 : s;
    endfunction

    function automatic int gain_exp(input int g, input int r);
        int s = 8192 + 4 * (4095 - r + g);
        return (s > 16383) ? 16383 : s;
    endfunction

    // Wait for done, then check its timing (R6) and the resulting coefficients.
    task automatic finish_and_check(input int g, input int r);
        int v = 0, seen = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            rd(3'd0, v);
            if (v[2]) begin seen = cyc; break; end
        end
        chk("R6 done one cycle after reference result", seen, vcyc + 1);
        chk("R6 ctrl start clear, done set", v & 5, 4);
        rd_coef(3'd2, v);
        chk("R4 offset coefficient", v, ofs_exp(g));
        rd_coef(3'd4, v);
        chk("R5 gain coefficient", v, gain_exp(g, r));
    endtask

    // Driver: queue expectations and launch one calibration.
    task automatic launch(input bit sys, input int gch, input int rch, input int g, input int r);
        int v;
        exp_ch.push_back(gch); exp_ch.push_back(rch);
        rsp_q.push_back(g);    rsp_q.push_back(r);
        wr(3'd0, {6'd0, sys, 1'b1});
        rd(3'd0, v);
        chk("R6 start sets busy and clears done", v & 5, 1);
    endtask

    // Monitor: answer each request after lat cycles, scoring channel and hold (R9).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && conv_req) begin
                if (exp_ch.size() == 0) begin
                    chk("R2 unexpected request", 1, 0);
                end else begin
                    chk("R2/R3 channel select", int'(chan_sel), exp_ch.pop_front());
                    for (int k = 0; k < lat; k++) begin
                        @(negedge clk);
                        chk("R9 request held", int'(conv_req), 1);
                    end
                    conv_data  = 12'(rsp_q.pop_front());
                    conv_valid = 1'b1;
                    vcyc = cyc;
                    @(negedge clk);
                    conv_valid = 1'b0;
                end
            end
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl reset", v, 0);
        rd(3'd2, v); chk("R1 offset low reset", v, 8'h00);
        rd(3'd3, v); chk("R1 offset high reset", v, 8'h20);
        rd(3'd5, v); chk("R1 gain high reset", v, 8'h20);
        chk("R1 conv_req reset", int'(conv_req), 0);
        chk("R1 chan_sel reset", int'(chan_sel), 0);

        // R7 direct coefficient writes while idle
        wr(3'd3, 8'hFF); wr(3'd2, 8'hA5);
        rd(3'd3, v); chk("R7 offset high masked to 6 bits", v, 8'h3F);
        rd(3'd2, v); chk("R7 offset low", v, 8'hA5);
        wr(3'd5, 8'h12); wr(3'd4, 8'h34);
        rd_coef(3'd4, v); chk("R7 gain write", v, 14'h1234);

        // R2 device mode, normal values
        launch(1'b0, 11, 12, 10, 4000);
        finish_and_check(10, 4000);

        // R3 system mode with user channels
        wr(3'd1, 8'h73);
        launch(1'b1, 3, 7, 200, 3500);
        finish_and_check(200, 3500);

        // R4/R5 saturation of both coefficients
        launch(1'b0, 11, 12, 3000, 100);
        finish_and_check(3000, 100);

        // R8 writes during calibration are ignored
        lat = 20;
        launch(1'b0, 11, 12, 50, 3900);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'hEE);
        wr(3'd0, 8'h03);
        finish_and_check(50, 3900);
        rd(3'd0, v); chk("R8 mode unchanged by busy write", (v >> 1) & 1, 0);
        rd(3'd1, v); chk("R8 channel reg unchanged", v, 8'h73);
        repeat (5) @(negedge clk);
        chk("R9 request low when idle", int'(conv_req), 0);
        chk("R2 queue drained", exp_ch.size(), 0);
        report();
    end

endmodule